// File: doc/BRIEF.md
# Crossing Signal Sequencer

This block runs the lamps where a busy main road crosses a lightly used side road. The main road is given green by default. The side road gets a turn only when a vehicle sensor reports a waiting car and the main road has already been green for at least the long interval. Every change of lamps goes through a yellow phase of fixed short length. A built-in interval counter measures both intervals. The controller clears that counter with a one-cycle restart pulse. The pulse is raised combinationally, in the same cycle that the phase decision is taken.

The block has four phases: main green, main yellow, side green and side yellow. The phase register can be laid out in one of four ways, chosen by a parameter: plain binary count, reflected binary, scrambled binary or one bit per phase. The behaviour at the pins is the same for every choice. With one bit per phase, any vector that is not exactly one-hot is treated as corrupt, and the next edge returns the register to main green. None of the pins carries streamed data. The sensor, the lamp codes and the restart pulse are plain level and pulse signals, with no valid/ready handshake and no back-pressure.

Top module: `xroad_signal_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, the lamps show main green with side red (hwy_lamp_o=00, farm_lamp_o=10), and restart_o is 0.
- R2: In main green, the phase holds and restart_o stays 0 in every cycle where the long interval has not elapsed or car_i is 0. A car that arrives early waits until the long interval has run out.
- R3: In main green, restart_o is 1 in the same cycle that car_i is 1 and the long interval has elapsed. The next cycle shows main yellow.
- R4: Main yellow lasts exactly SHORT_TICKS+1 cycles, and restart_o is 1 in its last cycle. car_i has no effect on this length.
- R5: Side green ends with restart_o=1 in the first cycle where car_i is 0 or the long interval has elapsed. With car_i held at 1 it lasts LONG_TICKS+1 cycles. With car_i at 0 on entry it lasts one cycle.
- R6: Side yellow lasts exactly SHORT_TICKS+1 cycles. It then returns to main green, with restart_o=1 in its last cycle.
- R7: The lamp codes are 00 for green, 01 for yellow and 10 for red. The main lamp reads 00, 01, 10, 10 and the side lamp reads 10, 10, 00, 01 in main green, main yellow, side green and side yellow respectively.
- R8: restart_o is 1 exactly in the cycles that end a phase. It clears the interval counter, so each phase times from zero. The long interval counts LONG_TICKS cycles and the short interval counts SHORT_TICKS cycles, both measured from the cycle after the pulse.
- R9: The parameter ENCODING selects the phase register layout: 0 binary (00,01,10,11), 1 reflected (00,01,11,10), 2 scrambled (00,10,01,11), 3 one bit per phase (0001,0010,0100,1000). The values are listed in the order main green, main yellow, side green, side yellow. All four give identical hwy_lamp_o, farm_lamp_o and restart_o in every cycle.
- R10: The two lamps are never green or yellow at the same time, and neither lamp ever shows the code 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| car_i | input | 1 | Side-road vehicle sensor, 1 when a car is waiting |
| hwy_lamp_o | output | 2 | Main-road lamp code |
| farm_lamp_o | output | 2 | Side-road lamp code |
| restart_o | output | 1 | Interval restart pulse, 1 in each phase-ending cycle |

## Verification
Several sensor patterns are used. A sensor that stays quiet shows that main green holds indefinitely. A car arriving after the long interval shows that the restart comes in the same cycle. A car arriving early shows that the long interval still gates the change. A car held through side green separates the long-interval exit from the sensor exit. Dropping the sensor partway through side green, or before it begins, exercises the early exits. Dropping it during main yellow shows that the yellow length ignores the sensor. All four register layouts run side by side on the same stimulus, and every pin is compared in every cycle, which exposes any layout whose next-phase decode differs.

// File: rtl/xroad_pkg.sv
package xroad_pkg;

  localparam int ENC_SEQ      = 0;
  localparam int ENC_GRAY     = 1;
  localparam int ENC_SCRAMBLE = 2;
  localparam int ENC_ONEHOT   = 3;

  typedef enum logic [1:0] {
    LAMP_GO      = 2'b00,
    LAMP_CAUTION = 2'b01,
    LAMP_STOP    = 2'b10
  } lamp_t;

  typedef enum logic [1:0] {
    PH_HWY_GO       = 2'd0,
    PH_HWY_CAUTION  = 2'd1,
    PH_FARM_GO      = 2'd2,
    PH_FARM_CAUTION = 2'd3
  } phase_t;

  function automatic int phase_width(input int enc);
    return (enc == ENC_ONEHOT) ? 4 : 2;
  endfunction

endpackage

// File: rtl/xroad_interval_timer.sv
module xroad_interval_timer #(
  parameter int SHORT_TICKS = 3,
  parameter int LONG_TICKS  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic short_done_o,
  output logic long_done_o
);
  localparam int CW = $clog2(LONG_TICKS + 1);
  localparam logic [CW-1:0] SHORT_V = CW'(SHORT_TICKS);
  localparam logic [CW-1:0] LONG_V  = CW'(LONG_TICKS);

  logic [CW-1:0] cnt_q;

  // saturating count from the cycle after each restart
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (restart_i)       cnt_q <= '0;
    else if (cnt_q != LONG_V) cnt_q <= cnt_q + 1'b1;
  end

  assign short_done_o = (cnt_q >= SHORT_V);
  assign long_done_o  = (cnt_q == LONG_V);
endmodule

// File: rtl/xroad_phase_reg.sv
module xroad_phase_reg
  import xroad_pkg::*;
#(
  parameter int ENCODING = ENC_ONEHOT
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   car_i,
  input  logic   short_done_i,
  input  logic   long_done_i,
  output phase_t phase_o,
  output logic   restart_o
);
  localparam int SW = phase_width(ENCODING);

  function automatic logic [SW-1:0] enc_of(input phase_t p);
    logic [1:0] b;
    case (ENCODING)
      ENC_GRAY:     b = {p[1], p[1] ^ p[0]};
      ENC_SCRAMBLE: b = {p[0], p[1]};
      default:      b = p;
    endcase
    if (ENCODING == ENC_ONEHOT) return SW'(1) << p;
    else                        return SW'(b);
  endfunction

  logic [SW-1:0] state_q;
  phase_t        cur_ph, nxt_ph;
  logic          matched, legal;

  // decode the stored vector back to a symbolic phase
  always_comb begin
    cur_ph  = PH_HWY_GO;
    matched = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (state_q == enc_of(phase_t'(2'(i)))) begin
        cur_ph  = phase_t'(2'(i));
        matched = 1'b1;
      end
    end
  end

  generate
    if (ENCODING == ENC_ONEHOT) begin : g_guard
      assign legal = matched && $onehot(state_q);
    end else begin : g_dense
      assign legal = matched;
    end
  endgenerate

  always_comb begin
    nxt_ph = cur_ph;
    case (cur_ph)
      PH_HWY_GO:       if (long_done_i && car_i)   nxt_ph = PH_HWY_CAUTION;
      PH_HWY_CAUTION:  if (short_done_i)           nxt_ph = PH_FARM_GO;
      PH_FARM_GO:      if (long_done_i || !car_i)  nxt_ph = PH_FARM_CAUTION;
      PH_FARM_CAUTION: if (short_done_i)           nxt_ph = PH_HWY_GO;
      default:                                     nxt_ph = PH_HWY_GO;
    endcase
    if (!legal) nxt_ph = PH_HWY_GO;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= enc_of(PH_HWY_GO);
    else         state_q <= enc_of(nxt_ph);
  end

  assign phase_o   = cur_ph;
  assign restart_o = !legal || (nxt_ph != cur_ph);
endmodule

// File: rtl/xroad_lamp_map.sv
module xroad_lamp_map
  import xroad_pkg::*;
(
  input  phase_t phase_i,
  output lamp_t  hwy_o,
  output lamp_t  farm_o
);
  always_comb begin
    hwy_o  = LAMP_STOP;
    farm_o = LAMP_STOP;
    case (phase_i)
      PH_HWY_GO:       hwy_o  = LAMP_GO;
      PH_HWY_CAUTION:  hwy_o  = LAMP_CAUTION;
      PH_FARM_GO:      farm_o = LAMP_GO;
      PH_FARM_CAUTION: farm_o = LAMP_CAUTION;
      default: ;
    endcase
  end
endmodule

// File: rtl/xroad_signal_ctrl.sv
module xroad_signal_ctrl
  import xroad_pkg::*;
#(
  parameter int ENCODING    = ENC_ONEHOT,
  parameter int SHORT_TICKS = 3,
  parameter int LONG_TICKS  = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       car_i,
  output logic [1:0] hwy_lamp_o,
  output logic [1:0] farm_lamp_o,
  output logic       restart_o
);
  logic   short_done, long_done, restart;
  phase_t phase;
  lamp_t  hwy, farm;

  xroad_interval_timer #(
    .SHORT_TICKS(SHORT_TICKS),
    .LONG_TICKS (LONG_TICKS)
  ) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (restart),
    .short_done_o(short_done),
    .long_done_o (long_done)
  );

  xroad_phase_reg #(
    .ENCODING(ENCODING)
  ) u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .car_i       (car_i),
    .short_done_i(short_done),
    .long_done_i (long_done),
    .phase_o     (phase),
    .restart_o   (restart)
  );

  xroad_lamp_map u_lamps (
    .phase_i(phase),
    .hwy_o  (hwy),
    .farm_o (farm)
  );

  assign hwy_lamp_o  = hwy;
  assign farm_lamp_o = farm;
  assign restart_o   = restart;
endmodule

// File: rtl/xroad_signal_ctrl_chk.sv
module xroad_signal_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       car_i,
  input logic [1:0] hwy_lamp_o,
  input logic [1:0] farm_lamp_o,
  input logic       restart_o
);
  a_r10_never_both_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hwy_lamp_o == 2'b10) || (farm_lamp_o == 2'b10));

  a_r10_no_bad_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hwy_lamp_o != 2'b11) && (farm_lamp_o != 2'b11));

  a_r3_leave_needs_car: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hwy_lamp_o == 2'b00 && restart_o) |-> car_i);

  a_r3_green_to_yellow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hwy_lamp_o == 2'b00 && restart_o) |=> (hwy_lamp_o == 2'b01));

  a_r5_side_empty_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (farm_lamp_o == 2'b00 && !car_i) |-> restart_o);

  a_r6_back_to_main: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (farm_lamp_o == 2'b01 && restart_o) |=> (hwy_lamp_o == 2'b00));

  a_r8_pulse_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> ({hwy_lamp_o, farm_lamp_o} != $past({hwy_lamp_o, farm_lamp_o})));

  a_r8_hold_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_o |=> $stable({hwy_lamp_o, farm_lamp_o}));
endmodule

bind xroad_signal_ctrl xroad_signal_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .car_i      (car_i),
  .hwy_lamp_o (hwy_lamp_o),
  .farm_lamp_o(farm_lamp_o),
  .restart_o  (restart_o)
);

// File: tb/sim_xroad_signal_ctrl.sv
`timescale 1ns/1ps
module sim_xroad_signal_ctrl;
  import xroad_pkg::*;

  localparam int SHORT = 3;
  localparam int LONG  = 8;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic car = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic [1:0] h0, f0, h1, f1, h2, f2, h3, f3;
  logic       s0, s1, s2, s3;

  xroad_signal_ctrl #(.ENCODING(ENC_ONEHOT), .SHORT_TICKS(SHORT), .LONG_TICKS(LONG)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .car_i(car), .hwy_lamp_o(h0), .farm_lamp_o(f0), .restart_o(s0));
  xroad_signal_ctrl #(.ENCODING(ENC_SEQ), .SHORT_TICKS(SHORT), .LONG_TICKS(LONG)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .car_i(car), .hwy_lamp_o(h1), .farm_lamp_o(f1), .restart_o(s1));
  xroad_signal_ctrl #(.ENCODING(ENC_GRAY), .SHORT_TICKS(SHORT), .LONG_TICKS(LONG)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .car_i(car), .hwy_lamp_o(h2), .farm_lamp_o(f2), .restart_o(s2));
  xroad_signal_ctrl #(.ENCODING(ENC_SCRAMBLE), .SHORT_TICKS(SHORT), .LONG_TICKS(LONG)) u3 (
    .clk_i(clk), .rst_ni(rst_n), .car_i(car), .hwy_lamp_o(h3), .farm_lamp_o(f3), .restart_o(s3));

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R9 / R10: every cycle, all layouts agree and lamps stay exclusive
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      check({h1, f1, s1} == {h0, f0, s0}, "R9", "binary layout vs one-hot", {h1, f1, s1}, {h0, f0, s0});
      check({h2, f2, s2} == {h0, f0, s0}, "R9", "reflected layout vs one-hot", {h2, f2, s2}, {h0, f0, s0});
      check({h3, f3, s3} == {h0, f0, s0}, "R9", "scrambled layout vs one-hot", {h3, f3, s3}, {h0, f0, s0});
      check(h0 == 2'b10 || f0 == 2'b10, "R10", "both lamps open", {h0, f0}, 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Counts cycles in the current phase before the restart pulse; captures
  // the lamps of its first cycle; optionally changes car at cycle set_at.
  task automatic await_change(input int set_at, input logic set_val,
                              output int n, output logic [1:0] hf, output logic [1:0] ff);
    n = 0;
    hf = 2'b11;
    ff = 2'b11;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (n == set_at) car = set_val;
      #1;
      if (n == 0) begin hf = h0; ff = f0; end
      if (s0) return;
      n++;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    car = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(h0 == 2'b00 && f0 == 2'b10, "R1", "lamps in reset", {h0, f0}, 4'b0010);
    check(s0 == 1'b0, "R1", "restart in reset", s0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(h0 == 2'b00 && f0 == 2'b10 && s0 == 1'b0, "R1", "first cycle after reset",
          {h0, f0, s0}, 5'b00100);
  endtask

  task automatic t_quiet_main();
    int seen = 0;
    for (int k = 0; k < LONG + 6; k++) begin
      @(negedge clk);
      #1;
      if (s0 || h0 != 2'b00) seen++;
    end
    check(seen == 0, "R2", "main green held without car", seen, 0);
  endtask

  task automatic t_late_car();
    int n;
    logic [1:0] hf, ff;
    @(negedge clk);
    car = 1'b1;
    #1;
    check(s0 == 1'b1, "R3", "restart same cycle as late car", s0, 1);
    check(h0 == 2'b00, "R3", "still green in decision cycle", h0, 0);
    await_change(-1, 1'b1, n, hf, ff);
    check(hf == 2'b01 && ff == 2'b10, "R7", "main yellow codes", {hf, ff}, 4'b0110);
    check(n == SHORT, "R4", "main yellow length", n, SHORT);
    await_change(-1, 1'b1, n, hf, ff);
    check(hf == 2'b10 && ff == 2'b00, "R7", "side green codes", {hf, ff}, 4'b1000);
    check(n == LONG, "R5", "side green ends on long interval", n, LONG);
    await_change(-1, 1'b1, n, hf, ff);
    check(hf == 2'b10 && ff == 2'b01, "R7", "side yellow codes", {hf, ff}, 4'b1001);
    check(n == SHORT, "R6", "side yellow length", n, SHORT);
  endtask

  task automatic t_car_waiting_on_entry();
    int n;
    logic [1:0] hf, ff;
    await_change(-1, 1'b1, n, hf, ff);
    check(hf == 2'b00 && ff == 2'b10, "R6", "back to main green", {hf, ff}, 4'b0010);
    check(n == LONG, "R2", "car present still waits long interval", n, LONG);
    await_change(1, 1'b0, n, hf, ff);
    check(n == SHORT, "R4", "yellow ignores car drop", n, SHORT);
    await_change(-1, 1'b0, n, hf, ff);
    check(hf == 2'b10 && ff == 2'b00, "R7", "side green shown once", {hf, ff}, 4'b1000);
    check(n == 0, "R5", "empty side road exits at once", n, 0);
    await_change(-1, 1'b0, n, hf, ff);
    check(n == SHORT, "R8", "timer restarted for side yellow", n, SHORT);
  endtask

  task automatic t_early_car_then_leave();
    int n;
    logic [1:0] hf, ff;
    await_change(2, 1'b1, n, hf, ff);
    check(n == LONG, "R2", "early car waits for long interval", n, LONG);
    await_change(-1, 1'b1, n, hf, ff);
    check(n == SHORT, "R4", "main yellow length again", n, SHORT);
    await_change(3, 1'b0, n, hf, ff);
    check(n == 3, "R5", "side green ends when car leaves", n, 3);
    await_change(-1, 1'b0, n, hf, ff);
    check(n == SHORT, "R6", "side yellow after early exit", n, SHORT);
    @(negedge clk);
    #1;
    check(s0 == 1'b0 && h0 == 2'b00, "R8", "single-cycle pulse then main green",
          {s0, h0}, 3'b000);
  endtask

  initial begin
    t_reset();
    t_quiet_main();
    t_late_car();
    t_car_waiting_on_entry();
    t_early_car_then_leave();
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule